// File: doc/BRIEF.md
# Four-Bit Five-Stage Pipelined Processor

A compact 4-bit load-store core that runs a fixed program held in a 16-word instruction ROM. Each instruction moves through five stages: fetch, decode, register access, execute and write-back. The stages are separated by edge-triggered stage registers. The program counter is a 4-bit carry look-ahead incrementer that advances on every clock and wraps around. The program therefore repeats forever and has no branch or stall. A one-hot row decode of the program counter selects the ROM word.

The ROM contents are a parameter. The only outputs are debug views of the program counter and of the four 4-bit registers. The core is used as a self-running datapath whose register state can be watched from outside. Data hazards between neighbouring instructions are resolved in hardware, so the register contents always match strictly sequential execution of the program.

Top module: `nibble_pipe_cpu`

## Requirements
- R1: After reset is released, the instruction at ROM address 0 updates the register file on the fifth rising edge. Before that edge the registers stay zero, and each later instruction lands exactly one edge after the one before it.
- R2: The program counter rises by one on every rising edge while reset is high, and wraps from 15 to 0.
- R3: While rst_n is low at a rising edge (synchronous, active low), the program counter, every stage register and all four registers are cleared to zero on that edge.
- R4: An instruction word is 9 bits. Bits [8:6] hold the opcode and bits [1:0] hold the destination register rd. In the register form, bits [3:2] hold the source register rs and bits [5:4] are ignored. In the immediate form, bits [5:2] hold a 4-bit value. Opcode 001 loads that value into rd.
- R5: The opcode map is as follows. 010 sets rd=rd+rs and 011 sets rd=rd-rs. 100, 101 and 110 set rd to rd AND, OR and XOR rs. 111 sets rd=rs. All results are truncated to 4 bits and no carry is kept.
- R6: Opcode 000 is a no-operation. It writes no register, whatever its other bits hold.
- R7: An instruction that reads a register written by the instruction just before it sees that new value.
- R8: An instruction that reads a register written two instructions earlier sees that new value. This happens through a same-cycle write-then-read bypass in the register file.
- R9: The ROM word fetched in a cycle is the one whose row is selected by a one-hot decode of the current program counter. Word k occupies bits [9k+8:9k] of ROM_IMAGE.
- R10: dbg_regs packs register r0 at bits [3:0], r1 at [7:4], r2 at [11:8] and r3 at [15:12]. dbg_pc shows the current program counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_pc | output | 4 | Current program counter |
| dbg_regs | output | 16 | The four registers, r0 in the low nibble |

## Verification
The embedded properties watch several behaviours on every cycle. They check the +1 step of the program counter, the clearing effect of reset, and that a write-back always lands in the addressed register. They also check that a cycle without a write leaves the register file untouched, and that the ROM row select is one-hot. The bench scenarios are needed for the rest. Only they show that the opcodes compute the right values, that back-to-back and two-apart dependencies see fresh data, and that a no-operation with junk fields writes nothing. They also show that a reset in mid-run flushes the instructions already in flight. These are checked by comparing the debug register view, edge by edge, against a sequential model of the program over several wraps of the program counter.

// File: rtl/nibble_pkg.sv
// Shared widths, opcode encoding and stage-register layouts for the
// four-bit pipelined processor. Assumes a 9-bit instruction word made of a
// 3-bit opcode and a 6-bit operand field.
package nibble_pkg;

    parameter int DATA_W  = 4;                  // datapath width
    parameter int PC_W    = 4;                  // program counter width
    parameter int ROM_DEP = 1 << PC_W;          // instruction words
    parameter int OP_W    = 3;                  // opcode width
    parameter int RADR_W  = 2;                  // register address width
    parameter int NREG    = 1 << RADR_W;        // register count
    parameter int INSTR_W = OP_W + 2 + 2 * RADR_W; // 9-bit word

    typedef enum logic [OP_W-1:0] {
        OP_NOP = 3'b000,
        OP_LDI = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b011,
        OP_AND = 3'b100,
        OP_ORR = 3'b101,
        OP_XOR = 3'b110,
        OP_MOV = 3'b111
    } op_e;

    // decode -> register access
    typedef struct packed {
        op_e               op;
        logic [RADR_W-1:0] rd;
        logic [RADR_W-1:0] rs;
        logic [DATA_W-1:0] imm;
        logic              wen;
    } dec_slot_t;

    // register access -> execute
    typedef struct packed {
        op_e               op;
        logic [RADR_W-1:0] rd;
        logic [RADR_W-1:0] rs;
        logic [DATA_W-1:0] val_d;
        logic [DATA_W-1:0] val_s;
        logic [DATA_W-1:0] imm;
        logic              wen;
    } opnd_slot_t;

    // execute -> write-back
    typedef struct packed {
        logic [RADR_W-1:0] rd;
        logic [DATA_W-1:0] res;
        logic              wen;
    } res_slot_t;

endpackage

// File: rtl/nibble_pc_cla.sv
// Carry look-ahead incrementer: adds a constant step to the program counter.
// Every carry is formed in flat generate/propagate form, not rippled.
// Assumes an unsigned constant step that fits in W bits; the result wraps.
module nibble_pc_cla #(
    parameter int W    = 4,
    parameter int STEP = 1
) (
    input  logic [W-1:0] cur,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] STEP_V = W'(STEP);

    logic [W-1:0] gen_t;
    logic [W-1:0] prop_t;
    logic [W-1:0] carry;
    logic         c_acc;
    logic         p_run;

    // bitwise generate and propagate terms against the constant step
    assign gen_t  = cur & STEP_V;
    assign prop_t = cur ^ STEP_V;

    // look-ahead carries: each carry is an OR of generate terms gated by propagate runs
    always_comb begin
        carry    = '0;
        c_acc    = 1'b0;
        p_run    = 1'b0;
        for (int i = 0; i < W - 1; i++) begin
            c_acc = gen_t[i];
            p_run = prop_t[i];
            for (int j = i - 1; j >= 0; j--) begin
                c_acc = c_acc | (p_run & gen_t[j]);
                p_run = p_run & prop_t[j];
            end
            carry[i+1] = c_acc;
        end
    end

    assign nxt = prop_t ^ carry;

endmodule

// File: rtl/nibble_irom.sv
// Instruction ROM read through a one-hot row decode of the address.
// Contents come from the IMAGE parameter, word k at bits [k*IW +: IW].
// Assumes DEPTH equals 2**AW so every address selects a real row.
module nibble_irom #(
    parameter int AW    = 4,
    parameter int IW    = 9,
    parameter int DEPTH = 1 << AW,
    parameter logic [DEPTH*IW-1:0] IMAGE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    output logic [IW-1:0] word
);
    logic [DEPTH-1:0] row_sel;

    // address-to-row decoder, one row line per word
    always_comb begin
        for (int k = 0; k < DEPTH; k++) begin
            row_sel[k] = (addr == AW'(k));
        end
    end

    // wired-OR of the selected row onto the word lines
    always_comb begin
        word = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (row_sel[k]) begin
                word = word | IMAGE[k*IW +: IW];
            end
        end
    end

    AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot(row_sel)); // R9

endmodule

// File: rtl/nibble_decode.sv
// Splits an instruction word into opcode, register fields, immediate and
// a write-enable. Purely combinational; the caller registers the result.
// Assumes the field layout given by nibble_pkg (rd in the low bits).
module nibble_decode
    import nibble_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_slot_t          slot
);
    localparam int OP_LSB = INSTR_W - OP_W;

    // field extraction; no-operation never requests a write
    always_comb begin
        slot.op  = op_e'(instr[INSTR_W-1:OP_LSB]);
        slot.rd  = instr[RADR_W-1:0];
        slot.rs  = instr[2*RADR_W-1:RADR_W];
        slot.imm = instr[RADR_W +: DATA_W];
        slot.wen = (slot.op != OP_NOP);
    end

endmodule

// File: rtl/nibble_alu.sv
// Four-bit ALU for the execute stage. The results wrap to the data width
// and no flags are produced. Operand d is the destination's old value and
// operand s is the source's.
module nibble_alu
    import nibble_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] opd_d,
    input  logic [DATA_W-1:0] opd_s,
    input  logic [DATA_W-1:0] imm,
    output logic [DATA_W-1:0] res
);
    // operation select
    always_comb begin
        unique case (op)
            OP_LDI:  res = imm;
            OP_ADD:  res = opd_d + opd_s;
            OP_SUB:  res = opd_d - opd_s;
            OP_AND:  res = opd_d & opd_s;
            OP_ORR:  res = opd_d | opd_s;
            OP_XOR:  res = opd_d ^ opd_s;
            OP_MOV:  res = opd_s;
            default: res = '0;
        endcase
    end

endmodule

// File: rtl/nibble_regfile.sv
// Register file with two read ports and one write port. A read of the
// register being written in the same cycle returns the incoming value
// (write-first bypass). Synchronous active-low reset clears every entry.
module nibble_regfile
    import nibble_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [RADR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic [RADR_W-1:0]      rd_addr_a,
    input  logic [RADR_W-1:0]      rd_addr_b,
    output logic [DATA_W-1:0]      rd_data_a,
    output logic [DATA_W-1:0]      rd_data_b,
    output logic [NREG*DATA_W-1:0] all_regs
);
    logic [DATA_W-1:0] mem [NREG];

    // write port with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < NREG; k++) begin
                mem[k] <= '0;
            end
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // read ports with write-first bypass
    assign rd_data_a = (wr_en && wr_addr == rd_addr_a) ? wr_data : mem[rd_addr_a];
    assign rd_data_b = (wr_en && wr_addr == rd_addr_b) ? wr_data : mem[rd_addr_b];

    // flat debug view, entry 0 in the low bits
    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign all_regs[g*DATA_W +: DATA_W] = mem[g];
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> all_regs[$past(wr_addr)*DATA_W +: DATA_W] == $past(wr_data)); // R1
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(all_regs)); // R6

endmodule

// File: rtl/nibble_pipe_cpu.sv
// Top level of the four-bit, five-stage processor. The five stages are
// fetch, decode, register access, execute and write-back. The PC steps
// every cycle and wraps. Hazards are resolved by the register-file bypass
// (two apart) and by forwarding the write-back slot into the ALU operands
// (back to back). Synchronous active-low reset.
module nibble_pipe_cpu
    import nibble_pkg::*;
#(
    parameter logic [ROM_DEP*INSTR_W-1:0] ROM_IMAGE = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    output logic [PC_W-1:0]        dbg_pc,
    output logic [NREG*DATA_W-1:0] dbg_regs
);
    logic [PC_W-1:0]    pc_q;
    logic [PC_W-1:0]    pc_inc;
    logic [INSTR_W-1:0] rom_word;
    logic [INSTR_W-1:0] fetch_q;
    dec_slot_t          dec_now;
    dec_slot_t          dec_q;
    opnd_slot_t         opnd_q;
    res_slot_t          res_q;
    logic [DATA_W-1:0]  rf_a;
    logic [DATA_W-1:0]  rf_b;
    logic [DATA_W-1:0]  fwd_d;
    logic [DATA_W-1:0]  fwd_s;
    logic [DATA_W-1:0]  alu_res;

    nibble_pc_cla #(.W(PC_W), .STEP(1)) u_pc_inc (
        .cur (pc_q),
        .nxt (pc_inc)
    );

    nibble_irom #(.AW(PC_W), .IW(INSTR_W), .DEPTH(ROM_DEP), .IMAGE(ROM_IMAGE)) u_irom (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (pc_q),
        .word  (rom_word)
    );

    nibble_decode u_dec (
        .instr (fetch_q),
        .slot  (dec_now)
    );

    nibble_regfile u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (res_q.wen),
        .wr_addr   (res_q.rd),
        .wr_data   (res_q.res),
        .rd_addr_a (dec_q.rd),
        .rd_addr_b (dec_q.rs),
        .rd_data_a (rf_a),
        .rd_data_b (rf_b),
        .all_regs  (dbg_regs)
    );

    // forwarding of the write-back slot into the execute operands
    always_comb begin
        fwd_d = (res_q.wen && res_q.rd == opnd_q.rd) ? res_q.res : opnd_q.val_d;
        fwd_s = (res_q.wen && res_q.rd == opnd_q.rs) ? res_q.res : opnd_q.val_s;
    end

    nibble_alu u_alu (
        .op    (opnd_q.op),
        .opd_d (fwd_d),
        .opd_s (fwd_s),
        .imm   (opnd_q.imm),
        .res   (alu_res)
    );

    // program counter and the four stage registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q    <= '0;
            fetch_q <= '0;
            dec_q   <= '0;
            opnd_q  <= '0;
            res_q   <= '0;
        end else begin
            pc_q         <= pc_inc;
            fetch_q      <= rom_word;
            dec_q        <= dec_now;
            opnd_q.op    <= dec_q.op;
            opnd_q.rd    <= dec_q.rd;
            opnd_q.rs    <= dec_q.rs;
            opnd_q.val_d <= rf_a;
            opnd_q.val_s <= rf_b;
            opnd_q.imm   <= dec_q.imm;
            opnd_q.wen   <= dec_q.wen;
            res_q.rd     <= opnd_q.rd;
            res_q.res    <= alu_res;
            res_q.wen    <= opnd_q.wen;
        end
    end

    assign dbg_pc = pc_q;

    AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> pc_q == $past(pc_q) + PC_W'(1)); // R2
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> (dbg_pc == '0 && dbg_regs == '0 && !res_q.wen)); // R3

endmodule

// File: tb/tb_nibble_pipe_cpu.sv
`timescale 1ns/1ps
// Scoreboard bench. A driver task runs a sequential model of the program
// and queues the expected register file after each instruction. A monitor
// pops one entry per edge once write-back starts.
module tb_nibble_pipe_cpu;

    // program: {op,imm,rd} or {op,2'b00,rs,rd}; word 15 first
    localparam logic [143:0] PROG = {
        9'b110001010,   // 15 XOR r2,r2
        9'b111000000,   // 14 MOV r0,r0
        9'b000000000,   // 13 NOP
        9'b101001001,   // 12 OR  r1,r2
        9'b011001100,   // 11 SUB r0,r3
        9'b010000111,   // 10 ADD r3,r1
        9'b001111111,   //  9 LDI r3,15
        9'b000111111,   //  8 NOP with junk fields
        9'b110000011,   //  7 XOR r3,r0
        9'b111001011,   //  6 MOV r3,r2
        9'b100000110,   //  5 AND r2,r1
        9'b001110010,   //  4 LDI r2,12
        9'b011000001,   //  3 SUB r1,r0
        9'b010000100,   //  2 ADD r0,r1
        9'b001001101,   //  1 LDI r1,3
        9'b001010100    //  0 LDI r0,5
    };

    typedef struct {
        logic [15:0] regs;
        string       tag;
        int          idx;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  dbg_pc;
    logic [15:0] dbg_regs;
    exp_t        sb_q[$];
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    nibble_pipe_cpu #(.ROM_IMAGE(PROG)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .dbg_pc   (dbg_pc),
        .dbg_regs (dbg_regs)
    );

    task automatic check(input string tag, input string what, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // driver: sequential reference model, one queue entry per instruction
    task automatic drive_program(input int count);
        logic [3:0] m [4];
        logic [1:0] p1_rd = 0, p2_rd = 0;
        bit         p1_w = 0, p2_w = 0;
        for (int k = 0; k < 4; k++) m[k] = 4'h0;
        for (int n = 0; n < count; n++) begin
            logic [8:0] w = PROG[(n % 16) * 9 +: 9];
            logic [2:0] op = w[8:6];
            logic [1:0] rd = w[1:0];
            logic [1:0] rs = w[3:2];
            logic [3:0] a = m[rd];
            logic [3:0] b = m[rs];
            exp_t e;
            string tg;
            bit wr = (op != 3'b000);
            case (op)
                3'b001: m[rd] = w[5:2];
                3'b010: m[rd] = a + b;
                3'b011: m[rd] = a - b;
                3'b100: m[rd] = a & b;
                3'b101: m[rd] = a | b;
                3'b110: m[rd] = a ^ b;
                3'b111: m[rd] = b;
                default: ;
            endcase
            if (n == 0)                                            tg = "R1";
            else if (!wr)                                          tg = "R6";
            else if (op == 3'b001)                                 tg = "R4";
            else if (p1_w && (p1_rd == rd || p1_rd == rs))         tg = "R7";
            else if (p2_w && (p2_rd == rd || p2_rd == rs))         tg = "R8";
            else                                                   tg = "R5";
            e.regs = {m[3], m[2], m[1], m[0]};
            e.tag  = tg;
            e.idx  = n;
            sb_q.push_back(e);
            p2_rd = p1_rd; p2_w = p1_w;
            p1_rd = rd;    p1_w = wr;
        end
    endtask

    // monitor: releases reset, then checks the PC and the scoreboard after each edge
    task automatic monitor_run(input int count);
        @(negedge clk);
        rst_n = 1'b1;
        for (int e = 1; e <= count + 4; e++) begin
            @(posedge clk);
            @(negedge clk);
            check("R2", "pc", {12'h0, dbg_pc}, 16'(e % 16));
            if (e < 5) begin
                check("R1", "regs before first write-back", dbg_regs, 16'h0);
            end else begin
                exp_t x = sb_q.pop_front();
                check(x.tag, $sformatf("regs after instr %0d (R9 R10)", x.idx), dbg_regs, x.regs);
            end
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R3", "pc in reset", {12'h0, dbg_pc}, 16'h0);
        check("R3", "regs in reset", dbg_regs, 16'h0);
    endtask

    initial begin
        apply_reset();
        drive_program(36);
        monitor_run(36);
        // mid-run reset: in-flight instructions must be flushed (R3)
        apply_reset();
        drive_program(20);
        monitor_run(20);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule